// File: doc/BRIEF.md
# Serial TDM Codec Channel Interface

This block is the digital front end of a telephony filter/codec that sits on a 2.048 MHz time-division serial bus. A sync input, active low and sampled on each rising bit-clock edge, marks the channel that belongs to this device. The address input qualifies that sync pulse. When a slot opens, the block shifts one 8-bit PCM word in from the bus and one 8-bit PCM word out onto it. In the same eight bit times it can also shift a serial control word into one of two control registers. The transmit line is driven only during the block's own slot. Outside the slot the enable is low and the line is released.

Toward the codec core, the transmit word arrives on a valid/ready port backed by a one-word holding buffer. `enc_ready` is high whenever the buffer is empty, and a word is taken on any cycle where `enc_valid` and `enc_ready` are both high. The buffer is emptied when a slot opens, and the new word waits for that slot. If the buffer is empty when a slot opens, the idle code goes out. The receive word leaves on a valid-only port. The serial bus cannot be stalled, so the receiver must take `dec_word` in the single cycle where `dec_valid` is high. The word then stays unchanged until the next slot ends.

The control registers set powerdown, filter gain, the analog and digital loopback flags, the test flag and six general-purpose drive outputs. With the address held low, the control input acts as a static level instead of a serial word.

Top module: `tdm_codec_port`

## Requirements
- R1: After reset, `pcm_tx_oe`, `pcm_tx`, `dec_valid` and every control output are 0, and `enc_ready` is 1.
- R2: A slot opens on a rising edge where `sync_n` is 0 and `addr` is 01 (mid) or 10 (high). `pcm_tx_oe` is then 1 for exactly the 8 cycles that follow that edge. With `addr` at 00, or with the reserved code 11, a sync pulse opens no slot.
- R3: Within a slot, `pcm_tx` carries the outgoing word MSB first. Bit 7 is on the line in the first slot cycle and bit 0 in the eighth.
- R4: `pcm_rx` is sampled MSB first on the 8 rising edges after the opening edge. After the eighth of those edges, `dec_word` holds the received word and `dec_valid` is 1 for exactly one cycle.
- R5: `enc_ready` is 1 exactly when the one-word holding buffer is empty. An accepted word is sent in the next slot to open after it was accepted. A word offered while `enc_ready` is 0 is not taken. A slot that opens with the buffer empty sends the idle code 8'hFF.
- R6: In a slot opened with `addr` 01, the control word shifted in MSB first on `ctl_in` is written as a whole into register A at slot end. Register A bits map as follows: bit 7 `pwr_down`, bit 6 `dig_loop`, bit 5 `ana_loop`, bit 4 `test_en`, bits 3:0 `gain_code`.
- R7: In a slot opened with `addr` 10, the control word goes to register B. Bits 5:0 drive `drv_out[5:0]`, bits 7:6 are ignored, and register A is left unchanged.
- R8: The control outputs change only in the cycle where `dec_valid` is 1. They never show a partly shifted word.
- R9: While `addr` is 00 and no slot is running, each cycle `pwr_down` becomes the inverse of the `ctl_in` level sampled on the previous edge, whatever register A holds. After the next slot opens, `pwr_down` follows register A bit 7 again.
- R10: If `dig_loop` is 1 when a slot opens, that slot transmits the word received in the previous slot, and the holding buffer keeps its word.
- R11: A sync pulse that arrives while a slot is running is ignored. The slot still lasts 8 cycles, and no second slot follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Active-low channel sync |
| addr | input | 2 | Encoded three-level address: 00 low, 01 mid, 10 high |
| ctl_in | input | 1 | Serial control word, or static level |
| pcm_rx | input | 1 | Serial PCM from the bus |
| pcm_tx | output | 1 | Serial PCM to the bus |
| pcm_tx_oe | output | 1 | Bus drive enable for pcm_tx |
| enc_valid | input | 1 | Transmit word offered |
| enc_ready | output | 1 | Holding buffer empty |
| enc_word | input | 8 | Transmit PCM word |
| dec_valid | output | 1 | Received word strobe |
| dec_word | output | 8 | Received PCM word |
| pwr_down | output | 1 | Powerdown request |
| gain_code | output | 4 | Filter gain code |
| dig_loop | output | 1 | Digital loopback |
| ana_loop | output | 1 | Analog loopback flag |
| test_en | output | 1 | Chip test flag |
| drv_out | output | 6 | General-purpose drive outputs, 1 = active |

## Verification
The assertions check four things on every cycle. First, the bus enable rises only after a qualified sync edge. Second, the receive strobe coincides with the end of a slot. Third, a handshake always fills the buffer. Fourth, the control outputs hold still except at slot end, and static-mode powerdown follows the sampled level. Some behaviour can only be seen through the bench's scenarios. These are the bit order on both serial lines, the field mapping of each register, the idle code, loopback, which word goes to which slot, and the ignored mid-slot sync.

// File: rtl/tdm_codec_pkg.sv
package tdm_codec_pkg;
  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    ADDR_LOW  = 2'b00,
    ADDR_MID  = 2'b01,
    ADDR_HIGH = 2'b10
  } addr_lvl_e;

  typedef struct packed {
    logic       pd;
    logic       dloop;
    logic       aloop;
    logic       test;
    logic [3:0] gain;
  } ctl_a_t;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_codec_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic [1:0] addr,
  output logic       start,
  output logic       active,
  output logic       last,
  output logic       tgt_b
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

  logic [CW-1:0] cnt;
  logic          addr_ok;

  // sync is only honoured between slots and with a mid/high address
  assign addr_ok = (addr == ADDR_MID) || (addr == ADDR_HIGH);
  assign start   = !sync_n && !active && addr_ok;
  assign last    = active && (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      tgt_b  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      tgt_b  <= (addr == ADDR_HIGH);
    end else if (active) begin
      cnt <= cnt + 1'b1;
      if (last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_pcm_path.sv
module tdm_pcm_path #(
  parameter int              WORD_W    = 8,
  parameter logic [WORD_W-1:0] IDLE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              last,
  input  logic              dloop,
  input  logic              pcm_rx,
  output logic              tx_bit,
  input  logic              enc_valid,
  output logic              enc_ready,
  input  logic [WORD_W-1:0] enc_word,
  output logic              dec_valid,
  output logic [WORD_W-1:0] dec_word
);
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-2:0] rx_sh;
  logic [WORD_W-1:0] last_rx;
  logic [WORD_W-1:0] rx_full;
  logic              take, use_hold;

  assign enc_ready = !hold_full;
  assign take      = enc_valid && enc_ready;
  assign use_hold  = start && !dloop && hold_full;
  assign rx_full   = {rx_sh, pcm_rx};
  assign tx_bit    = tx_sh[WORD_W-1];

  // one-word holding buffer toward the encoder
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_word <= '0;
    end else if (use_hold) begin
      hold_full <= 1'b0;
    end else if (take) begin
      hold_full <= 1'b1;
      hold_word <= enc_word;
    end
  end

  // transmit shifter, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (start) begin
      if (dloop)          tx_sh <= last_rx;
      else if (hold_full) tx_sh <= hold_word;
      else                tx_sh <= IDLE_CODE;
    end else if (active) begin
      tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  // receive shifter and word delivery
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      last_rx   <= '0;
      dec_word  <= '0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= last;
      if (active) rx_sh <= rx_full[WORD_W-2:0];
      if (last) begin
        dec_word <= rx_full;
        last_rx  <= rx_full;
      end
    end
  end
endmodule

// File: rtl/tdm_ctl_regs.sv
module tdm_ctl_regs
  import tdm_codec_pkg::*;
#(
  parameter int DRV_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             last,
  input  logic             tgt_b,
  input  logic [1:0]       addr,
  input  logic             ctl_in,
  output ctl_a_t           reg_a,
  output logic [DRV_N-1:0] drv,
  output logic             pwr_down
);
  logic [CTL_W-2:0] ctl_sh;
  logic [CTL_W-1:0] word;
  logic             st_mode, st_low;
  logic             load_a, load_b;

  assign word   = {ctl_sh, ctl_in};
  assign load_a = last && !tgt_b;
  assign load_b = last && tgt_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_sh <= '0;
    else if (active) ctl_sh <= word[CTL_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_a <= '0;
    else if (load_a) reg_a <= ctl_a_t'(word);
  end

  // drive outputs, each bit loaded as part of the whole word
  for (genvar g = 0; g < DRV_N; g++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      drv[g] <= 1'b0;
      else if (load_b) drv[g] <= word[g];
    end
  end

  // static level mode with the address held low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mode <= 1'b0;
      st_low  <= 1'b0;
    end else if (start) begin
      st_mode <= 1'b0;
    end else if (!active && addr == ADDR_LOW) begin
      st_mode <= 1'b1;
      st_low  <= !ctl_in;
    end
  end

  assign pwr_down = st_mode ? st_low : reg_a.pd;
endmodule

// File: rtl/tdm_codec_port.sv
module tdm_codec_port
  import tdm_codec_pkg::*;
#(
  parameter int               DRV_N     = 6,
  parameter logic [CTL_W-1:0] IDLE_CODE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic [1:0]       addr,
  input  logic             ctl_in,
  input  logic             pcm_rx,
  output logic             pcm_tx,
  output logic             pcm_tx_oe,
  input  logic             enc_valid,
  output logic             enc_ready,
  input  logic [CTL_W-1:0] enc_word,
  output logic             dec_valid,
  output logic [CTL_W-1:0] dec_word,
  output logic             pwr_down,
  output logic [3:0]       gain_code,
  output logic             dig_loop,
  output logic             ana_loop,
  output logic             test_en,
  output logic [DRV_N-1:0] drv_out
);
  logic   start, active, last, tgt_b, tx_bit;
  ctl_a_t reg_a;

  tdm_slot_timer #(.WORD_W(CTL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .addr(addr),
    .start(start), .active(active), .last(last), .tgt_b(tgt_b)
  );

  tdm_pcm_path #(.WORD_W(CTL_W), .IDLE_CODE(IDLE_CODE)) u_pcm (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .last(last),
    .dloop(reg_a.dloop), .pcm_rx(pcm_rx), .tx_bit(tx_bit),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_word(enc_word),
    .dec_valid(dec_valid), .dec_word(dec_word)
  );

  tdm_ctl_regs #(.DRV_N(DRV_N)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .last(last),
    .tgt_b(tgt_b), .addr(addr), .ctl_in(ctl_in),
    .reg_a(reg_a), .drv(drv_out), .pwr_down(pwr_down)
  );

  assign pcm_tx_oe = active;
  assign pcm_tx    = active & tx_bit;
  assign gain_code = reg_a.gain;
  assign dig_loop  = reg_a.dloop;
  assign ana_loop  = reg_a.aloop;
  assign test_en   = reg_a.test;
endmodule

// File: rtl/tdm_codec_port_chk.sv
module tdm_codec_port_chk #(
  parameter int DRV_N = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n,
  input logic [1:0]       addr,
  input logic             ctl_in,
  input logic             pcm_tx_oe,
  input logic             enc_valid,
  input logic             enc_ready,
  input logic             dec_valid,
  input logic             pwr_down,
  input logic [3:0]       gain_code,
  input logic             dig_loop,
  input logic             ana_loop,
  input logic             test_en,
  input logic [DRV_N-1:0] drv_out
);
  AST_OE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_tx_oe) |-> (!$past(sync_n) && ($past(addr) == 2'b01 || $past(addr) == 2'b10))); // R2

  AST_DEC_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $fell(pcm_tx_oe)); // R4

  AST_BUF_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_ready) |=> !enc_ready); // R5

  AST_CTL_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> ($stable(drv_out) && $stable(gain_code) && $stable(dig_loop)
                    && $stable(ana_loop) && $stable(test_en))); // R8

  AST_STATIC_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'b00 && !pcm_tx_oe) |=> (pwr_down == !$past(ctl_in))); // R9
endmodule

bind tdm_codec_port tdm_codec_port_chk #(.DRV_N(DRV_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .addr(addr), .ctl_in(ctl_in),
  .pcm_tx_oe(pcm_tx_oe), .enc_valid(enc_valid), .enc_ready(enc_ready),
  .dec_valid(dec_valid), .pwr_down(pwr_down), .gain_code(gain_code),
  .dig_loop(dig_loop), .ana_loop(ana_loop), .test_en(test_en), .drv_out(drv_out)
);

// File: tb/tdm_codec_port_test.sv
module tdm_codec_port_test;
  localparam int CLK_P = 488;

  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, ctl_in = 1'b1, pcm_rx = 1'b0;
  logic [1:0] addr = 2'b01;
  logic enc_valid = 1'b0;
  logic [7:0] enc_word = '0;
  logic pcm_tx, pcm_tx_oe, enc_ready, dec_valid, pwr_down, dig_loop, ana_loop, test_en;
  logic [7:0] dec_word;
  logic [3:0] gain_code;
  logic [5:0] drv_out;
  int total = 0, bad = 0;
  bit done = 0;

  tdm_codec_port uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .addr(addr), .ctl_in(ctl_in),
    .pcm_rx(pcm_rx), .pcm_tx(pcm_tx), .pcm_tx_oe(pcm_tx_oe),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_word(enc_word),
    .dec_valid(dec_valid), .dec_word(dec_word), .pwr_down(pwr_down),
    .gain_code(gain_code), .dig_loop(dig_loop), .ana_loop(ana_loop),
    .test_en(test_en), .drv_out(drv_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] snap();
    return {pwr_down, dig_loop, ana_loop, test_en, gain_code, drv_out};
  endfunction

  task automatic offer(input logic [7:0] w);
    @(negedge clk); enc_valid = 1'b1; enc_word = w;
    @(negedge clk); enc_valid = 1'b0;
  endtask

  task automatic run_slot(input logic [1:0] a, input logic [7:0] rxw, input logic [7:0] cw,
                          input bit glitch, output logic [7:0] txw, output logic [7:0] decw,
                          output int oe_n, output logic [13:0] s0, output logic [13:0] s7,
                          output logic dv);
    @(negedge clk); sync_n = 1'b0; addr = a;
    @(negedge clk); sync_n = 1'b1;
    oe_n = 0;
    for (int k = 0; k < 8; k++) begin
      pcm_rx = rxw[7-k];
      ctl_in = cw[7-k];
      sync_n = (glitch && k == 3) ? 1'b0 : 1'b1;
      txw[7-k] = pcm_tx;
      if (pcm_tx_oe) oe_n++;
      if (k == 0) s0 = snap();
      if (k == 7) s7 = snap();
      @(negedge clk);
    end
    sync_n = 1'b1; ctl_in = 1'b1;
    dv = dec_valid; decw = dec_word;
    if (pcm_tx_oe) oe_n++;
  endtask

  logic [7:0] tx, dw;
  int on;
  logic [13:0] sa, sb;
  logic dv;

  task automatic t_reset();
    chk(pcm_tx_oe == 0 && pcm_tx == 0 && dec_valid == 0, "R1 bus/strobe", {pcm_tx_oe, pcm_tx, dec_valid}, 0);
    chk(snap() == 0, "R1 control outputs", snap(), 0);
    chk(enc_ready == 1, "R1 ready", enc_ready, 1);
  endtask

  task automatic t_basic();
    offer(8'hA5);
    chk(enc_ready == 0, "R5 ready after accept", enc_ready, 0);
    run_slot(2'b01, 8'h3C, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'hA5, "R3 tx word MSB first", tx, 8'hA5);
    chk(dw == 8'h3C && dv == 1, "R4 rx word", dw, 8'h3C);
    chk(on == 8, "R2 enable length", on, 8);
    @(negedge clk);
    chk(dec_valid == 0, "R4 single strobe", dec_valid, 0);
    chk(enc_ready == 1, "R5 buffer emptied", enc_ready, 1);
  endtask

  task automatic t_idle();
    run_slot(2'b01, 8'hC3, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'hFF, "R5 idle code", tx, 8'hFF);
    chk(dw == 8'hC3, "R4 rx second pattern", dw, 8'hC3);
  endtask

  task automatic t_backpressure();
    offer(8'h11);
    @(negedge clk); enc_valid = 1'b1; enc_word = 8'h22;
    @(negedge clk); @(negedge clk);
    chk(enc_ready == 0, "R5 held while full", enc_ready, 0);
    enc_valid = 1'b0;
    run_slot(2'b01, 8'h00, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'h11, "R5 first word kept", tx, 8'h11);
    run_slot(2'b01, 8'h00, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'hFF, "R5 refused word not sent", tx, 8'hFF);
  endtask

  task automatic t_reg_a();
    run_slot(2'b01, 8'h00, 8'h9B, 0, tx, dw, on, sa, sb, dv);
    chk(sa == 0 && sb == 0, "R8 no partial update", sb, 0);
    chk(pwr_down == 1 && dig_loop == 0 && ana_loop == 0 && test_en == 1, "R6 flags",
        {pwr_down, dig_loop, ana_loop, test_en}, 4'b1001);
    chk(gain_code == 4'hB, "R6 gain", gain_code, 4'hB);
  endtask

  task automatic t_reg_b();
    run_slot(2'b10, 8'h00, 8'hFF, 0, tx, dw, on, sa, sb, dv);
    chk(drv_out == 6'h3F, "R7 drive all", drv_out, 6'h3F);
    chk(gain_code == 4'hB && pwr_down == 1, "R7 reg A untouched", gain_code, 4'hB);
    run_slot(2'b10, 8'h00, 8'hC5, 0, tx, dw, on, sa, sb, dv);
    chk(drv_out == 6'h05, "R7 upper bits ignored", drv_out, 6'h05);
  endtask

  task automatic t_static();
    int oe_seen = 0;
    @(negedge clk); addr = 2'b00; ctl_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pwr_down == 0, "R9 static high", pwr_down, 0);
    ctl_in = 1'b0;
    @(negedge clk);
    chk(pwr_down == 1, "R9 static low", pwr_down, 1);
    sync_n = 1'b0;
    @(negedge clk); sync_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (pcm_tx_oe) oe_seen++;
      @(negedge clk);
    end
    chk(oe_seen == 0, "R2 no slot at low address", oe_seen, 0);
    ctl_in = 1'b1;
    run_slot(2'b01, 8'h00, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(sa[13] == 1, "R9 back to register A", sa[13], 1);
    chk(pwr_down == 0, "R9 follows new register A", pwr_down, 0);
  endtask

  task automatic t_glitch();
    run_slot(2'b01, 8'h5A, 8'h00, 1, tx, dw, on, sa, sb, dv);
    chk(on == 8, "R11 slot length kept", on, 8);
    chk(dw == 8'h5A, "R11 rx intact", dw, 8'h5A);
    @(negedge clk);
    chk(pcm_tx_oe == 0 && dec_valid == 0, "R11 no second slot", {pcm_tx_oe, dec_valid}, 0);
  endtask

  task automatic t_loop();
    run_slot(2'b01, 8'h77, 8'h40, 0, tx, dw, on, sa, sb, dv);
    chk(dig_loop == 1, "R6 loop flag", dig_loop, 1);
    offer(8'h99);
    run_slot(2'b01, 8'h12, 8'h40, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'h77, "R10 loop word", tx, 8'h77);
    chk(enc_ready == 0, "R10 buffer kept", enc_ready, 0);
    run_slot(2'b01, 8'h34, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'h12, "R10 loop second word", tx, 8'h12);
    run_slot(2'b01, 8'h00, 8'h00, 0, tx, dw, on, sa, sb, dv);
    chk(tx == 8'h99, "R10 buffered word after loop", tx, 8'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_idle();
    t_backpressure();
    t_reg_a();
    t_reg_b();
    t_static();
    t_glitch();
    t_loop();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule